// File: doc/BRIEF.md
# Nonvolatile Image Load Sequencer

This block moves bytes between a byte-wide nonvolatile store and a 256-entry volatile register image that the rest of the chip reads. Its operations are started by writing a 16-bit command word. A command either copies the whole store into the image or moves one byte in either direction at an address carried in the command word. As soon as reset is released, the block starts a full copy on its own.

After every full copy the block forms an 8-bit sum over image bytes 0 to 117 and compares it with byte 118. It reports the sum and whether the two agree. The store sits outside the block and answers each request through a request/acknowledge handshake that may take any number of cycles. Ordinary register writes from the host reach only the volatile image. The store changes only when a single-byte write command is given.

Top module: `nvr_loader`

## Requirements
- R1: When reset is released, a full copy starts with no command. Busy is 1 from the first cycle after reset. Done, match and the sum field read 0 while reset is held.
- R2: Command word field [1:0] is the opcode, bit 5 is the direction (0 = store to image, 1 = image to store) and [15:8] is the byte address. Opcode 00 or 11 with bit 5 = 0 starts a full copy. Opcode 10 starts a single-byte transfer. Opcode 01, and opcode 00 or 11 with bit 5 = 1, start nothing and leave busy and done unchanged.
- R3: A full copy reads store addresses 0 to 255 in ascending order and writes each byte to the same image entry.
- R4: At the end of each full copy, the sum field holds the low 8 bits of the sum of bytes 0 to 117, and the match bit is 1 exactly when that sum equals byte 118.
- R5: A single-byte read copies the store byte at the command address into that image entry and leaves every other entry unchanged.
- R6: A single-byte write copies the image entry at the command address into the store at the same address, using exactly one store write.
- R7: A host image write changes only the addressed image entry and never the store. A host image write issued while busy is ignored.
- R8: A command word written while busy is ignored. It is not queued and causes no store access.
- R9: Starting a command clears done and match. Done is set in the cycle busy falls. After a single-byte command, match stays 0 and the sum field keeps its previous value.
- R10: A store request keeps its address and direction steady until acknowledged. Each acknowledge completes exactly one byte transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | One-cycle strobe that writes the command word |
| ctrl_word | input | 16 | Command word: opcode [1:0], direction [5], address [15:8] |
| host_wr | input | 1 | Host write strobe to the volatile image |
| host_addr | input | 8 | Host write address |
| host_wdata | input | 8 | Host write data |
| host_raddr | input | 8 | Image read address |
| host_rdata | output | 8 | Image read data (combinational) |
| nv_req | output | 1 | Store request, held until acknowledged |
| nv_we | output | 1 | Store direction: 1 = write |
| nv_addr | output | 8 | Store byte address |
| nv_wdata | output | 8 | Byte to be written to the store |
| nv_ack | input | 1 | One-cycle store acknowledge |
| nv_rdata | input | 8 | Store read data, valid with nv_ack |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | The last operation has finished |
| csum_val | output | 8 | Sum from the last full copy |
| csum_ok | output | 1 | Sum from the last full copy matched byte 118 |

## Verification
The assertions assume the store acknowledges only while a request is pending, raises acknowledge for a single cycle, and leaves at least one cycle without acknowledge before the next one. The bench's store model answers after a fixed latency and then drops acknowledge for one cycle before it looks at the request again, so it stays within these assumptions. The bench drives command and host strobes for exactly one cycle. It sends some of them deliberately while a copy is running, to show they are dropped.

// File: rtl/nvr_pkg.sv
// Package nvr_pkg
// Shared widths and the decoded operation type for the image load sequencer.
// Assumes a byte-wide store and an image of 2**NVR_AW entries.
package nvr_pkg;
    localparam int NVR_AW = 8;
    localparam int NVR_DW = 8;
    localparam int NVR_CW = 16;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_FULL = 2'd1,
        OP_BRD  = 2'd2,
        OP_BWR  = 2'd3
    } nvr_op_e;
endpackage

// File: rtl/nvr_cmd_decode.sv
// Module nvr_cmd_decode
// Turns a command word into an operation and a byte address.
// Assumes opcode in [1:0], direction in [5] and address in the top AW bits.
// Combinational only.
module nvr_cmd_decode
    import nvr_pkg::*;
#(
    parameter int CW = NVR_CW,
    parameter int AW = NVR_AW
) (
    input  logic [CW-1:0] word,
    output nvr_op_e       op,
    output logic [AW-1:0] byte_addr
);
    localparam int DIR_BIT = 5;

    // Map opcode and direction onto an operation; other combinations do nothing.
    always_comb begin
        op = OP_NONE;
        unique case (word[1:0])
            2'b00, 2'b11: op = word[DIR_BIT] ? OP_NONE : OP_FULL;
            2'b10:        op = word[DIR_BIT] ? OP_BWR : OP_BRD;
            default:      op = OP_NONE;
        endcase
    end

    // The address of a single-byte transfer sits in the upper bits.
    always_comb byte_addr = word[CW-1 -: AW];
endmodule

// File: rtl/nvr_image.sv
// Module nvr_image
// Volatile register image with two write ports and two combinational reads.
// The loader port wins when both ports write in the same cycle. The caller
// gates the host port while an operation runs.
module nvr_image #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_data,
    input  logic [AW-1:0] rd_a_addr,
    output logic [DW-1:0] rd_a_data,
    input  logic [AW-1:0] rd_b_addr,
    output logic [DW-1:0] rd_b_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Clear on reset, then take one write per cycle, loader first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (ld_we) begin
            mem[ld_addr] <= ld_data;
        end else if (host_we) begin
            mem[host_addr] <= host_data;
        end
    end

    // Read port A serves the host.
    always_comb rd_a_data = mem[rd_a_addr];

    // Read port B supplies bytes going to the store.
    always_comb rd_b_data = mem[rd_b_addr];
endmodule

// File: rtl/nvr_csum.sv
// Module nvr_csum
// Accumulates the 8-bit sum of bytes 0..LAST during a full copy and captures
// the reference byte at REF. Assumes bytes arrive in ascending address order,
// starting at address 0.
module nvr_csum #(
    parameter int AW   = 8,
    parameter int DW   = 8,
    parameter int LAST = 117,
    parameter int REF  = 118
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output logic [DW-1:0] sum,
    output logic [DW-1:0] ref_byte
);
    localparam logic [AW-1:0] LAST_A = AW'(LAST);
    localparam logic [AW-1:0] REF_A  = AW'(REF);

    // Restart at address 0 and add each byte up to LAST.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum <= '0;
        end else if (valid && addr == '0) begin
            sum <= data;
        end else if (valid && addr <= LAST_A) begin
            sum <= sum + data;
        end
    end

    // Capture the stored reference byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_byte <= '0;
        end else if (valid && addr == REF_A) begin
            ref_byte <= data;
        end
    end
endmodule

// File: rtl/nvr_seq.sv
// Module nvr_seq
// Operation sequencer. Starts a full copy when reset is released, then
// accepts one decoded operation at a time while idle. It keeps a store
// request open until acknowledged, and publishes done, sum and match at the
// end of each operation. Assumes nv_ack is a single-cycle pulse that comes
// only while a request is open.
module nvr_seq
    import nvr_pkg::*;
#(
    parameter int AW = NVR_AW,
    parameter int DW = NVR_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  nvr_op_e       cmd_op,
    input  logic [AW-1:0] cmd_addr,
    output logic          nv_req,
    output logic          nv_we,
    output logic [AW-1:0] cur_addr,
    input  logic          nv_ack,
    output logic          ld_we,
    output logic          full_byte,
    input  logic [DW-1:0] sum_in,
    input  logic [DW-1:0] ref_in,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] csum_val,
    output logic          csum_ok
);
    localparam logic [AW-1:0] TOP_A = {AW{1'b1}};

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_XFER = 2'd1,
        S_FIN  = 2'd2
    } seq_st_e;

    seq_st_e state;
    nvr_op_e mode;
    logic    start;

    // A command is taken only while idle and only if it names an operation.
    always_comb start = (state == S_IDLE) && cmd_valid && (cmd_op != OP_NONE);

    // State, mode and address tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_XFER;
            mode     <= OP_FULL;
            cur_addr <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    state    <= S_XFER;
                    mode     <= cmd_op;
                    cur_addr <= (cmd_op == OP_FULL) ? '0 : cmd_addr;
                end
                S_XFER: if (nv_ack) begin
                    if (mode == OP_FULL && cur_addr != TOP_A) begin
                        cur_addr <= cur_addr + 1'b1;
                    end else begin
                        state <= S_FIN;
                    end
                end
                S_FIN:   state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Done and match are cleared at start; done, sum and match are published at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            csum_ok  <= 1'b0;
            csum_val <= '0;
        end else if (start) begin
            done    <= 1'b0;
            csum_ok <= 1'b0;
        end else if (state == S_FIN) begin
            done <= 1'b1;
            if (mode == OP_FULL) begin
                csum_val <= sum_in;
                csum_ok  <= (sum_in == ref_in);
            end
        end
    end

    // Handshake and image-write strobes.
    always_comb begin
        nv_req    = (state == S_XFER);
        nv_we     = (mode == OP_BWR);
        ld_we     = nv_req && nv_ack && (mode != OP_BWR);
        full_byte = ld_we && (mode == OP_FULL);
        busy      = (state != S_IDLE);
    end
endmodule

// File: rtl/nvr_loader.sv
// Module nvr_loader
// Top level of the image load sequencer: command decode, sequencer, volatile
// image and checksum. Host image writes are dropped while busy, so the image
// stays stable under a transfer. The store is external and speaks the
// nv_req / nv_ack handshake.
module nvr_loader
    import nvr_pkg::*;
#(
    parameter int AW     = NVR_AW,
    parameter int DW     = NVR_DW,
    parameter int CW     = NVR_CW,
    parameter int CS_END = 117,
    parameter int CS_REF = 118
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_wr,
    input  logic [CW-1:0] ctrl_word,
    input  logic          host_wr,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    input  logic [AW-1:0] host_raddr,
    output logic [DW-1:0] host_rdata,
    output logic          nv_req,
    output logic          nv_we,
    output logic [AW-1:0] nv_addr,
    output logic [DW-1:0] nv_wdata,
    input  logic          nv_ack,
    input  logic [DW-1:0] nv_rdata,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] csum_val,
    output logic          csum_ok
);
    nvr_op_e       dec_op;
    logic [AW-1:0] dec_addr;
    logic          ld_we;
    logic          full_byte;
    logic [DW-1:0] sum_w;
    logic [DW-1:0] ref_w;
    logic          host_we_g;

    nvr_cmd_decode #(.CW(CW), .AW(AW)) u_dec (
        .word      (ctrl_word),
        .op        (dec_op),
        .byte_addr (dec_addr)
    );

    nvr_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (ctrl_wr),
        .cmd_op    (dec_op),
        .cmd_addr  (dec_addr),
        .nv_req    (nv_req),
        .nv_we     (nv_we),
        .cur_addr  (nv_addr),
        .nv_ack    (nv_ack),
        .ld_we     (ld_we),
        .full_byte (full_byte),
        .sum_in    (sum_w),
        .ref_in    (ref_w),
        .busy      (busy),
        .done      (done),
        .csum_val  (csum_val),
        .csum_ok   (csum_ok)
    );

    // Host writes reach the image only while the sequencer is idle.
    always_comb host_we_g = host_wr && !busy;

    nvr_image #(.AW(AW), .DW(DW)) u_img (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_we     (ld_we),
        .ld_addr   (nv_addr),
        .ld_data   (nv_rdata),
        .host_we   (host_we_g),
        .host_addr (host_addr),
        .host_data (host_wdata),
        .rd_a_addr (host_raddr),
        .rd_a_data (host_rdata),
        .rd_b_addr (nv_addr),
        .rd_b_data (nv_wdata)
    );

    nvr_csum #(.AW(AW), .DW(DW), .LAST(CS_END), .REF(CS_REF)) u_cs (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (full_byte),
        .addr     (nv_addr),
        .data     (nv_rdata),
        .sum      (sum_w),
        .ref_byte (ref_w)
    );
endmodule

// File: rtl/nvr_loader_chk.sv
// Module nvr_loader_chk
// Port-level properties of nvr_loader, attached with bind.
module nvr_loader_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          nv_req,
    input logic          nv_we,
    input logic [AW-1:0] nv_addr,
    input logic          nv_ack,
    input logic          ctrl_wr,
    input logic          busy,
    input logic          done,
    input logic          csum_ok
);
    // R10: an open request holds address and direction until acknowledged.
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        nv_req && !nv_ack |=> nv_req && $stable(nv_addr) && $stable(nv_we));

    // R10: requests are made only during an operation.
    p_req_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        nv_req |-> busy);

    // R9: a new operation begins with done and match cleared.
    p_start_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !done && !csum_ok);

    // R9: done never shows while busy.
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R4: a match is reported only for a finished operation.
    p_ok_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        csum_ok |-> done);

    // R8: a command during an unacknowledged request does not move the request.
    p_busy_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && ctrl_wr && nv_req && !nv_ack |=> $stable(nv_addr));
endmodule

bind nvr_loader nvr_loader_chk #(.AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .nv_req  (nv_req),
    .nv_we   (nv_we),
    .nv_addr (nv_addr),
    .nv_ack  (nv_ack),
    .ctrl_wr (ctrl_wr),
    .busy    (busy),
    .done    (done),
    .csum_ok (csum_ok)
);

// File: tb/tb_nvr_loader.sv
// Bench for nvr_loader: a behavioural store with fixed latency, a table of
// single-byte reads, then directed tests.
module tb_nvr_loader;
    localparam int CLK_PERIOD = 10;
    localparam int NV_LAT     = 3;
    localparam int WD_CYCLES  = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [15:0] ctrl_word = '0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_raddr = '0;
    logic [7:0]  host_rdata;
    logic        nv_req, nv_we;
    logic [7:0]  nv_addr, nv_wdata;
    logic        nv_ack = 1'b0;
    logic [7:0]  nv_rdata = '0;
    logic        busy, done, csum_ok;
    logic [7:0]  csum_val;

    logic [7:0]  nvm [256];
    logic [7:0]  exp_img [256];
    int          nv_writes = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc = 0;

    // {address, new store byte} pairs for the single-byte read table.
    localparam logic [15:0] VEC [6] = '{
        16'h00_5A, 16'hFF_C3, 16'h75_01, 16'h76_FE, 16'h10_00, 16'h80_81
    };

    nvr_loader dut (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_word(ctrl_word),
        .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_raddr(host_raddr), .host_rdata(host_rdata),
        .nv_req(nv_req), .nv_we(nv_we), .nv_addr(nv_addr), .nv_wdata(nv_wdata),
        .nv_ack(nv_ack), .nv_rdata(nv_rdata),
        .busy(busy), .done(done), .csum_val(csum_val), .csum_ok(csum_ok)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural store: answers after NV_LAT falling edges, then skips one.
    initial begin
        int cnt;
        cnt = 0;
        forever begin
            @(negedge clk);
            if (nv_ack) begin
                nv_ack = 1'b0;
            end else if (rst_n && nv_req) begin
                cnt++;
                if (cnt == NV_LAT) begin
                    cnt = 0;
                    nv_ack = 1'b1;
                    nv_rdata = nvm[nv_addr];
                    if (nv_we) begin
                        nvm[nv_addr] = nv_wdata;
                        nv_writes++;
                    end
                end
            end else begin
                cnt = 0;
            end
        end
    end

    // Watchdog.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc == WD_CYCLES) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: run hung, cycles %0d expected < %0d", cyc, WD_CYCLES);
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    function automatic logic [7:0] exp_sum();
        logic [7:0] s;
        s = '0;
        for (int i = 0; i <= 117; i++) s = s + nvm[i];
        return s;
    endfunction

    function automatic logic [15:0] mkcmd(input logic [1:0] op, input logic dir, input logic [7:0] a);
        return {a, 2'b00, dir, 3'b000, op};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic send_cmd(input logic [15:0] w);
        @(negedge clk);
        ctrl_word = w; ctrl_wr = 1'b1;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic host_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [7:0] d);
        host_raddr = a;
        #1 d = host_rdata;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            if (!busy) return;
            @(negedge clk);
        end
        check("R10 timeout waiting for idle", busy, 0);
    endtask

    task automatic full_image_check(input string req);
        int bad;
        logic [7:0] d;
        bad = 0;
        for (int i = 0; i < 256; i++) begin
            peek(8'(i), d);
            if (d !== exp_img[i]) bad++;
        end
        check(req, bad, 0);
    endtask

    initial begin
        logic [7:0] d;
        logic [7:0] s;
        for (int i = 0; i < 256; i++) nvm[i] = 8'(i * 13 + 5);
        nvm[118] = exp_sum();

        // Reset state (R1).
        repeat (4) @(negedge clk);
        check("R1 busy during reset", busy, 1);
        check("R1 done during reset", done, 0);
        check("R1 match during reset", csum_ok, 0);
        check("R1 sum during reset", csum_val, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after release", busy, 1);
        wait_idle();
        for (int i = 0; i < 256; i++) exp_img[i] = nvm[i];
        full_image_check("R3 image after reset copy");
        check("R4 sum after reset copy", csum_val, exp_sum());
        check("R4 match after reset copy", csum_ok, 1);
        check("R9 done after reset copy", done, 1);

        // Table of single-byte reads (R5).
        foreach (VEC[k]) begin
            logic [7:0] a;
            logic [7:0] nb;
            a = VEC[k][15:8];
            nvm[a] = VEC[k][7:0];
            exp_img[a] = VEC[k][7:0];
            send_cmd(mkcmd(2'b10, 1'b0, a));
            wait_idle();
            peek(a, d);
            check("R5 byte read target", d, VEC[k][7:0]);
            nb = a + 8'd1;
            peek(nb, d);
            check("R5 byte read neighbour", d, exp_img[nb]);
            check("R9 match stays 0 after byte op", csum_ok, 0);
            check("R9 done after byte op", done, 1);
        end

        // Full copy with opcode 11 (R2, R4).
        send_cmd(mkcmd(2'b11, 1'b0, 8'h00));
        check("R2 opcode 11 starts copy", busy, 1);
        wait_idle();
        full_image_check("R3 image after opcode 11 copy");
        s = exp_sum();
        check("R4 sum after edits", csum_val, s);
        check("R4 match after edits", csum_ok, (s == nvm[118]) ? 1 : 0);

        // Host write touches image only (R7), then a byte write (R6).
        nv_writes = 0;
        host_write(8'd41, 8'h3C);
        peek(8'd41, d);
        check("R7 host write reaches image", d, 8'h3C);
        check("R7 host write leaves store", nvm[41], exp_img[41]);
        host_write(8'd40, 8'hA5);
        send_cmd(mkcmd(2'b10, 1'b1, 8'd40));
        wait_idle();
        check("R6 byte write store value", nvm[40], 8'hA5);
        check("R6 one store write", nv_writes, 1);
        check("R7 no store write for host byte", nvm[41], exp_img[41]);
        exp_img[40] = 8'hA5;

        // Ignored encodings (R2).
        send_cmd(mkcmd(2'b01, 1'b0, 8'd3));
        check("R2 opcode 01 ignored busy", busy, 0);
        check("R2 opcode 01 ignored done", done, 1);
        send_cmd(mkcmd(2'b00, 1'b1, 8'd3));
        check("R2 opcode 00 dir 1 ignored", busy, 0);
        send_cmd(mkcmd(2'b11, 1'b1, 8'd3));
        check("R2 opcode 11 dir 1 ignored", busy, 0);

        // Commands and host writes while busy are dropped (R8, R7).
        send_cmd(mkcmd(2'b00, 1'b0, 8'h00));
        check("R9 done cleared at start", done, 0);
        nv_writes = 0;
        repeat (20) @(negedge clk);
        send_cmd(mkcmd(2'b10, 1'b1, 8'd0));
        repeat (780) @(negedge clk);
        host_write(8'd10, 8'hEE);
        wait_idle();
        repeat (3) @(negedge clk);
        check("R8 no queued command", busy, 0);
        check("R8 no store write while busy", nv_writes, 0);
        peek(8'd10, d);
        check("R7 host write while busy ignored", d, nvm[10]);
        peek(8'd41, d);
        check("R3 copy restores host-edited byte", d, nvm[41]);
        s = exp_sum();
        check("R4 sum after byte write", csum_val, s);
        check("R4 match after byte write", csum_ok, (s == nvm[118]) ? 1 : 0);

        // Repair byte 118, write it back, re-copy (R4, R6).
        host_write(8'd118, s);
        send_cmd(mkcmd(2'b10, 1'b1, 8'd118));
        wait_idle();
        check("R6 reference byte written", nvm[118], s);
        send_cmd(mkcmd(2'b00, 1'b0, 8'h00));
        wait_idle();
        check("R4 match after repair", csum_ok, 1);
        check("R4 sum after repair", csum_val, s);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule